// File: doc/BRIEF.md
# Block Transfer and Search DMA Engine

This block is a single-channel DMA sequencer. It moves a block of bytes from one port to the other, scans a block for a byte value, or does both at once. Each of the two ports, A and B, has its own address generator. An address can count up, count down or stay fixed, and it always starts from a programmed start address. A small register interface sets the start addresses, the block length, the direction, the compare pattern with its ignore mask and the operating policy. Start and reset commands are written to a command register. Status, the byte counter and both current addresses can be read back.

The engine asks for the bus with a request/grant handshake. Each byte is then handled in a simple step: one read strobe from the source port, then, if writing is enabled, one write strobe to the destination port. A ready input throttles this work. Its active level can be programmed, or it can be overridden. Three policies set how the bus is held. Byte policy gives the bus back after every byte. Burst policy gives it back when ready goes inactive. Continuous policy keeps the bus and pauses until the block is finished or a stop-on-match occurs. At the end of a block the engine either stops or restarts by itself from the start addresses.

Top module: `xfer_seek_dma`

## Requirements
- R1: After rst_n the engine is idle. bus_req, rd_stb and wr_stb are low, and the status word (read index 0) and the byte counter (read index 1) both read 0.
- R2: Each port address advances once per byte handled. Control mode 00 increments it, 01 decrements it, and 1x holds it. Port A's mode is control bits [4:3] and port B's is bits [6:5]. Both start from the start address written at index 0 (A) or index 1 (B). Read index 2 returns A's current address and read index 3 returns B's.
- R3: A block handles exactly length+1 bytes, where length is written at index 2. When the block ends without auto restart, the counter reads length+1 and status bit 0 (end-of-block) is set and stays set.
- R4: Byte policy (control bits [8:7] = 00) drops bus_req in the cycle after each byte and then requests the bus again for the next byte.
- R5: Burst policy (01) drops bus_req while ready is inactive. It requests the bus again and finishes the block once ready returns.
- R6: Continuous policy (1x) keeps bus_req high while ready is inactive and issues no strobes until ready returns.
- R7: With compare enabled (control bit 1), a byte matches the pattern at index 4 bits [7:0] when every bit position equals the pattern. Positions that are set in the mask at index 4 bits [15:8] are ignored.
- R8: With stop-on-match (control bit 9), a matching byte ends the operation. The bus is released, status bit 1 (match) is set, status bit 2 (busy) clears and no further bytes are handled.
- R9: With auto restart (control bit 10), end-of-block sets status bit 0, clears the counter and reloads both addresses from their start values. The engine then carries on and stays busy.
- R10: Ready counts as active when rdy equals control bit 11. If control bit 12 is set, ready is taken as always active. While ready is inactive, an idle engine does not request the bus.
- R11: When control bit 0 (write enable) is clear, only source reads happen and wr_stb never rises.
- R12: Writing index 5 with bit 1 set (reset command) clears all status flags and returns the engine to idle with bus_req low. Writing index 5 with only bit 0 set (start command) clears the counter, loads both addresses and sets busy.
- R13: Control bit 2 picks the source port: 0 reads from A and writes to B, 1 reads from B and writes to A. port_sel shows which port drives mem_addr, with 0 meaning A.
- R14: rd_stb and wr_stb are never high together, and neither is high unless bus_grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register write index |
| cfg_wdata | input | 16 | Register write data |
| rd_addr | input | 2 | Readback index |
| rd_data | output | 16 | Readback data |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| rdy | input | 1 | Peripheral ready |
| mem_addr | output | 16 | Address of the port being accessed |
| port_sel | output | 1 | Port being accessed (0 = A, 1 = B) |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| din | input | 8 | Read data |
| dout | output | 8 | Write data |

## Verification
A byte counter that is off by one shows up at the end of the block. One byte too many or too few is written to the destination, and the counter readback is wrong as soon as busy clears. A stuck or misrouted address generator writes bytes to the wrong locations within the first two bytes. A sequencer that misreads the bus policy shows at bus_req within two to three cycles of a ready change or of a byte completing. A compare that ignores the mask either stops on the wrong byte or never stops, and the counter and match flag show this once the block ends.

// File: rtl/xsd_pkg.sv
`timescale 1ns/1ps
package xsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_OWN, ST_RD, ST_WR
  } seq_state_e;

  // register write indices
  localparam logic [2:0] IX_START_A = 3'd0;
  localparam logic [2:0] IX_START_B = 3'd1;
  localparam logic [2:0] IX_LENGTH  = 3'd2;
  localparam logic [2:0] IX_CTRL    = 3'd3;
  localparam logic [2:0] IX_CMP     = 3'd4;
  localparam logic [2:0] IX_CMD     = 3'd5;

  // control word bit positions
  localparam int CB_WRITE = 0;
  localparam int CB_CMP   = 1;
  localparam int CB_DIR   = 2;
  localparam int CB_AMODE = 3;
  localparam int CB_BMODE = 5;
  localparam int CB_HOLD  = 7;
  localparam int CB_SOM   = 9;
  localparam int CB_AUTO  = 10;
  localparam int CB_LVL   = 11;
  localparam int CB_FORCE = 12;
  localparam int CTRL_W   = 13;

  // bus holding policies
  localparam logic [1:0] HOLD_BYTE  = 2'b00;
  localparam logic [1:0] HOLD_BURST = 2'b01;
endpackage

// File: rtl/xsd_addr_gen.sv
`timescale 1ns/1ps
module xsd_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    mode,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a, input logic [1:0] m);
    if (m[1])      return a;
    else if (m[0]) return a - 1'b1;
    else           return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= start_addr;
    else if (step) addr <= advance(addr, mode);
  end

  p_fixed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode[1]) |=> $stable(addr));
  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode == 2'b00) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/xsd_match.sv
`timescale 1ns/1ps
module xsd_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] pattern,
  input  logic [DW-1:0] ignore,
  output logic          hit
);
  function automatic logic masked_equal(input logic [DW-1:0] d, input logic [DW-1:0] p,
                                        input logic [DW-1:0] m);
    return ((d ^ p) & ~m) == '0;
  endfunction

  assign hit = masked_equal(data, pattern, ignore);
endmodule

// File: rtl/xsd_seq.sv
`timescale 1ns/1ps
module xsd_seq import xsd_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       abort,
  input  logic       ready_ok,
  input  logic       grant,
  input  logic [1:0] hold,
  input  logic       do_write,
  input  logic       finish_stop,
  output logic       bus_req,
  output logic       rd_stb,
  output logic       wr_stb,
  output logic       step_done
);
  seq_state_e st, nxt;
  logic is_cont;
  logic own_stall;

  assign is_cont   = hold[1];
  assign own_stall = (st == ST_OWN) && run && !abort && !ready_ok;
  assign step_done = !abort && (((st == ST_RD) && !do_write) || (st == ST_WR));

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE: if (run && ready_ok && !abort) nxt = ST_REQ;
      ST_REQ:  if (abort || !run) nxt = ST_IDLE;
               else if (grant)    nxt = ST_OWN;
      ST_OWN:  if (abort || !run) nxt = ST_IDLE;
               else if (ready_ok) nxt = ST_RD;
               else if (!is_cont) nxt = ST_IDLE;
      ST_RD:   if (abort)         nxt = ST_IDLE;
               else if (do_write) nxt = ST_WR;
               else               nxt = (finish_stop || hold == HOLD_BYTE) ? ST_IDLE : ST_OWN;
      ST_WR:   if (abort)         nxt = ST_IDLE;
               else               nxt = (finish_stop || hold == HOLD_BYTE) ? ST_IDLE : ST_OWN;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign bus_req = (st != ST_IDLE);
  assign rd_stb  = (st == ST_RD);
  assign wr_stb  = (st == ST_WR);

  p_strobe_granted_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (grant && !(rd_stb && wr_stb)));
  p_byte_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && hold == HOLD_BYTE) |=> !bus_req);
  p_burst_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_stall && !is_cont) |=> !bus_req);
  p_cont_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_stall && is_cont) |=> (bus_req && !rd_stb));
  p_no_dest_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !do_write) |=> !wr_stb);
endmodule

// File: rtl/xfer_seek_dma.sv
`timescale 1ns/1ps
module xfer_seek_dma import xsd_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [15:0]   cfg_wdata,
  input  logic [1:0]    rd_addr,
  output logic [15:0]   rd_data,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          rdy,
  output logic [AW-1:0] mem_addr,
  output logic          port_sel,
  output logic          rd_stb,
  output logic          wr_stb,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int RW = 16;

  logic [1:0][AW-1:0] start_addr, cur_addr;
  logic [1:0][1:0]    port_mode;
  logic [CW-1:0]      blk_len, count;
  logic [CTRL_W-1:0]  ctl;
  logic [DW-1:0]      pattern, ignore, data_q, cmp_data;
  logic               run, flag_eob, flag_match;

  // decoded control fields
  logic do_write, do_cmp, dir, som, auto_rs, lvl, force_rdy;
  logic [1:0] hold;
  assign do_write     = ctl[CB_WRITE];
  assign do_cmp       = ctl[CB_CMP];
  assign dir          = ctl[CB_DIR];
  assign port_mode[0] = ctl[CB_AMODE +: 2];
  assign port_mode[1] = ctl[CB_BMODE +: 2];
  assign hold         = ctl[CB_HOLD +: 2];
  assign som          = ctl[CB_SOM];
  assign auto_rs      = ctl[CB_AUTO];
  assign lvl          = ctl[CB_LVL];
  assign force_rdy    = ctl[CB_FORCE];

  // named events for checking
  logic start_cmd, reset_cmd, ready_ok, raw_hit, hit, last, stop_m;
  logic step_done, finish_stop, halt_evt, restart_evt;

  assign reset_cmd   = cfg_we && cfg_addr == IX_CMD && cfg_wdata[1];
  assign start_cmd   = cfg_we && cfg_addr == IX_CMD && cfg_wdata[0] && !cfg_wdata[1];
  assign ready_ok    = force_rdy || (rdy == lvl);
  assign cmp_data    = rd_stb ? din : data_q;
  assign hit         = do_cmp && raw_hit;
  assign last        = (count == blk_len);
  assign stop_m      = som && hit;
  assign finish_stop = stop_m || (last && !auto_rs);
  assign halt_evt    = step_done && finish_stop;
  assign restart_evt = step_done && last && auto_rs && !stop_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      blk_len    <= '0;
      ctl        <= '0;
      pattern    <= '0;
      ignore     <= '0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        IX_START_A: start_addr[0] <= cfg_wdata[AW-1:0];
        IX_START_B: start_addr[1] <= cfg_wdata[AW-1:0];
        IX_LENGTH:  blk_len       <= cfg_wdata[CW-1:0];
        IX_CTRL:    ctl           <= cfg_wdata[CTRL_W-1:0];
        IX_CMP:     begin pattern <= cfg_wdata[DW-1:0]; ignore <= cfg_wdata[2*DW-1:DW]; end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; flag_eob <= 1'b0; flag_match <= 1'b0;
      count <= '0; data_q <= '0;
    end else begin
      if (reset_cmd)      run <= 1'b0;
      else if (start_cmd) run <= 1'b1;
      else if (halt_evt)  run <= 1'b0;

      if (reset_cmd) begin
        flag_eob <= 1'b0; flag_match <= 1'b0;
      end else begin
        if (step_done && last) flag_eob   <= 1'b1;
        if (step_done && hit)  flag_match <= 1'b1;
      end

      if (start_cmd)      count <= '0;
      else if (step_done) count <= restart_evt ? '0 : count + 1'b1;

      if (rd_stb) data_q <= din;
    end
  end

  xsd_match #(.DW(DW)) u_match (
    .data(cmp_data), .pattern(pattern), .ignore(ignore), .hit(raw_hit)
  );

  xsd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .abort(reset_cmd), .ready_ok(ready_ok),
    .grant(bus_grant), .hold(hold), .do_write(do_write), .finish_stop(finish_stop),
    .bus_req(bus_req), .rd_stb(rd_stb), .wr_stb(wr_stb), .step_done(step_done)
  );

  for (genvar p = 0; p < 2; p++) begin : g_port
    xsd_addr_gen #(.AW(AW)) u_ag (
      .clk(clk), .rst_n(rst_n), .load(start_cmd || restart_evt), .step(step_done),
      .start_addr(start_addr[p]), .mode(port_mode[p]), .addr(cur_addr[p])
    );
  end

  assign port_sel = wr_stb ? ~dir : dir;
  assign mem_addr = cur_addr[port_sel];
  assign dout     = data_q;

  always_comb begin
    unique case (rd_addr)
      2'd0:    rd_data = RW'({run, flag_match, flag_eob});
      2'd1:    rd_data = RW'(count);
      2'd2:    rd_data = RW'(cur_addr[0]);
      default: rd_data = RW'(cur_addr[1]);
    endcase
  end

  p_match_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && stop_m && !start_cmd) |=> (!run && flag_match));
  p_block_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && last && !auto_rs && !start_cmd) |=> (count == $past(blk_len) + 1'b1));
  p_restart_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_evt && !reset_cmd) |=> (run && count == '0 && flag_eob));
  p_reset_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (!run && !flag_eob && !flag_match && !bus_req));
endmodule

// File: tb/sim_xfer_seek_dma.sv
`timescale 1ns/1ps
module sim_xfer_seek_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, rd_data;
  logic [1:0] rd_addr = '0;
  logic bus_req, bus_grant, rdy = 1'b1;
  logic [15:0] mem_addr;
  logic port_sel, rd_stb, wr_stb;
  logic [7:0] din, dout;
  logic [7:0] mem [0:255];
  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, req_rise = 0;
  logic req_d = 1'b0;

  always #2.5 clk = ~clk;

  xfer_seek_dma u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_req(bus_req), .bus_grant(bus_grant),
    .rdy(rdy), .mem_addr(mem_addr), .port_sel(port_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .din(din), .dout(dout)
  );

  assign din = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) bus_grant <= 1'b0;
    else        bus_grant <= bus_req;
    req_d <= bus_req;
    if (bus_req && !req_d) req_rise <= req_rise + 1;
    if (rd_stb) rd_cnt <= rd_cnt + 1;
    if (wr_stb) begin
      wr_cnt <= wr_cnt + 1;
      mem[mem_addr[7:0]] <= dout;
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [15:0] ctl_word(input bit wr, input bit cmp, input bit dir,
      input logic [1:0] am, input logic [1:0] bm, input logic [1:0] hold,
      input bit som, input bit ar, input bit lvl, input bit frc);
    return {3'b0, frc, lvl, ar, som, hold, bm, am, dir, cmp, wr};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic fill_mem();
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] s;
    s = 16'h4;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      rd_reg(2'd0, s);
      if (!s[2]) break;
    end
    chk(req, 32'(s[2]), 0);
  endtask

  task automatic setup(input logic [15:0] sa, input logic [15:0] sb,
                       input logic [15:0] len, input logic [15:0] c);
    wr_reg(3'd0, sa); wr_reg(3'd1, sb); wr_reg(3'd2, len); wr_reg(3'd3, c);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 strobes", 32'({rd_stb, wr_stb}), 0);
    rd_reg(2'd0, v); chk("R1 status", 32'(v), 0);
    rd_reg(2'd1, v); chk("R1 counter", 32'(v), 0);
  endtask

  task automatic t_byte_copy();
    logic [15:0] v;
    int r0;
    fill_mem();
    setup(16'h10, 16'h40, 16'd3, ctl_word(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 1, 0));
    r0 = req_rise;
    wr_reg(3'd5, 16'h1);
    wait_idle("R3 byte block done");
    for (int i = 0; i < 4; i++) chk("R13 A->B copy", 32'(mem[8'h40 + i]), 32'(pat(8'h10 + i)));
    chk("R3 no extra byte", 32'(mem[8'h44]), 32'(pat(8'h44)));
    rd_reg(2'd1, v); chk("R3 counter len+1", 32'(v), 4);
    rd_reg(2'd0, v); chk("R3 eob flag", 32'(v), 1);
    rd_reg(2'd2, v); chk("R2 A incremented", 32'(v), 32'h14);
    rd_reg(2'd3, v); chk("R2 B incremented", 32'(v), 32'h44);
    chk("R4 one request per byte", 32'(req_rise - r0), 4);
  endtask

  task automatic t_dec_fixed();
    logic [15:0] v;
    fill_mem();
    wr_reg(3'd5, 16'h2);
    setup(16'h60, 16'h2F, 16'd2, ctl_word(1, 0, 1, 2'b10, 2'b01, 2'b01, 0, 0, 1, 0));
    wr_reg(3'd5, 16'h1);
    wait_idle("R2 burst block done");
    chk("R13 B->A last byte at fixed A", 32'(mem[8'h60]), 32'(pat(8'h2D)));
    chk("R13 neighbour untouched", 32'(mem[8'h61]), 32'(pat(8'h61)));
    rd_reg(2'd3, v); chk("R2 B decremented", 32'(v), 32'h2C);
    rd_reg(2'd2, v); chk("R2 A fixed", 32'(v), 32'h60);
  endtask

  task automatic t_ready_policy(input logic [1:0] hold, input logic [15:0] dst);
    logic [15:0] v;
    int r0;
    fill_mem();
    wr_reg(3'd5, 16'h2);
    setup(16'h00, dst, 16'd9, ctl_word(1, 0, 0, 2'b00, 2'b00, hold, 0, 0, 1, 0));
    wr_reg(3'd5, 16'h1);
    repeat (8) @(negedge clk);
    rdy = 1'b0;
    repeat (3) @(negedge clk);
    r0 = rd_cnt;
    repeat (5) @(negedge clk);
    if (hold == 2'b01) begin
      chk("R5 burst releases on not-ready", 32'(bus_req), 0);
    end else begin
      chk("R6 continuous holds bus", 32'(bus_req), 1);
      chk("R6 no reads while paused", 32'(rd_cnt - r0), 0);
    end
    rdy = 1'b1;
    wait_idle(hold == 2'b01 ? "R5 resumes" : "R6 resumes");
    rd_reg(2'd1, v); chk("R3 counter after paused block", 32'(v), 10);
    chk("R5 R6 last byte copied", 32'(mem[dst[7:0] + 9]), 32'(pat(9)));
  endtask

  task automatic t_search();
    logic [15:0] v;
    int w0;
    fill_mem();
    wr_reg(3'd5, 16'h2);
    @(negedge clk);
    mem[8'h80] <= 8'h12; mem[8'h81] <= 8'h4A; mem[8'h82] <= 8'h53; mem[8'h83] <= 8'h5A;
    wr_reg(3'd4, {8'h0F, 8'h5A});
    setup(16'h80, 16'hF0, 16'd15, ctl_word(0, 1, 0, 2'b00, 2'b00, 2'b01, 1, 0, 1, 0));
    w0 = wr_cnt;
    wr_reg(3'd5, 16'h1);
    wait_idle("R8 stops on match");
    rd_reg(2'd1, v); chk("R7 masked match at third byte", 32'(v), 3);
    rd_reg(2'd0, v); chk("R8 match flag, no eob", 32'(v), 2);
    chk("R8 bus released", 32'(bus_req), 0);
    chk("R11 no writes in search", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_auto_restart();
    logic [15:0] v;
    int w0;
    fill_mem();
    wr_reg(3'd5, 16'h2);
    setup(16'h30, 16'hA0, 16'd1, ctl_word(1, 0, 0, 2'b00, 2'b00, 2'b10, 0, 1, 1, 0));
    w0 = wr_cnt;
    wr_reg(3'd5, 16'h1);
    for (int k = 0; k < 500 && wr_cnt < w0 + 7; k++) @(negedge clk);
    rd_reg(2'd0, v); chk("R9 busy with eob set", 32'(v), 5);
    chk("R9 dest reloaded, no overrun", 32'(mem[8'hA2]), 32'(pat(8'hA2)));
    chk("R9 second byte copied", 32'(mem[8'hA1]), 32'(pat(8'h31)));
    wr_reg(3'd5, 16'h2);
    @(negedge clk);
    chk("R12 bus released", 32'(bus_req), 0);
    rd_reg(2'd0, v); chk("R12 status cleared", 32'(v), 0);
    rd_reg(2'd1, v); chk("R9 counter below two", 32'(v < 2), 1);
  endtask

  task automatic t_ready_level();
    logic [15:0] v;
    fill_mem();
    wr_reg(3'd5, 16'h2);
    rdy = 1'b1;
    setup(16'h05, 16'hE0, 16'd0, ctl_word(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0));
    wr_reg(3'd5, 16'h1);
    repeat (10) @(negedge clk);
    chk("R10 no request when not ready", 32'(bus_req), 0);
    rd_reg(2'd1, v); chk("R10 nothing handled", 32'(v), 0);
    wr_reg(3'd3, ctl_word(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 1));
    wait_idle("R10 force ready");
    chk("R10 forced copy", 32'(mem[8'hE0]), 32'(pat(5)));
    rdy = 1'b0;
    setup(16'h06, 16'hE1, 16'd0, ctl_word(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0));
    wr_reg(3'd5, 16'h1);
    wait_idle("R10 active-low ready");
    chk("R10 active-low copy", 32'(mem[8'hE1]), 32'(pat(6)));
    rdy = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_copy();
    t_dec_fixed();
    t_ready_policy(2'b01, 16'hC0);
    t_ready_policy(2'b10, 16'hD0);
    t_search();
    t_auto_restart();
    t_ready_level();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule